// File: doc/BRIEF.md
# Parallel RGB Panel Scan Timer

This block produces the scan timing for a parallel RGB panel. It has a pixel clock enable from a programmable divider, a line counter and a frame counter that step through the sync, back porch, active and front porch segments, and the horizontal sync, vertical sync and data-enable strobes, each with its own polarity. Every porch, pulse width and active size arrives as a configuration input. Each one holds the count minus one, so an all-zero field means one pixel or one line.

The counters are brought out so that a downstream pixel fetch can address its buffers. An active-area flag marks the visible pixels. When enabled, a single-cycle frame pulse marks the first cycle of vertical sync in each new frame. If the divider field is zero, the divider is bypassed: the enable is high on every cycle and the pixel clock output is the source clock itself.

Top module: `rgb_scan_timer`

## Requirements
- R1: While `rst_n` is low at a rising edge (synchronous reset), both counters, the divider phase and `frame_irq` return to zero.
- R2: A line is `(hs_wid_m1+1)+(hbp_m1+1)+(hact_m1+1)+(hfp_m1+1)` pixel ticks long. `pix_cnt` counts from 0 and wraps to 0 after the last tick. The horizontal sync segment covers counts below `hs_wid_m1+1`, followed in order by the back porch, the active region and the front porch.
- R3: A frame is the same four-segment sum, taken over the vertical fields, in lines. `line_cnt` advances only on the tick that wraps `pix_cnt`. The vertical sync covers lines below `vs_wid_m1+1`.
- R4: `active_o` is high exactly when both counters lie inside their active segments. Horizontally the active segment runs from `hs_wid_m1+hbp_m1+2` for `hact_m1+1` pixels; the vertical segment is defined the same way.
- R5: `hsync_o`, `vsync_o`, `de_o` and `pclk_o` are active high (high during sync, high when active, high in the first half of a pixel period). Setting `inv_hs`, `inv_vs`, `inv_de` or `inv_pclk` inverts the corresponding output.
- R6: With `pclk_div_m1 = N > 0`, `pix_ce` is high once every N+1 cycles. The counters change only on cycles where `pix_ce` is high. The un-inverted `pclk_o` is high for the first floor((N+1)/2) cycles of each period.
- R7: With `pclk_div_m1 = 0`, `pix_ce` is high on every cycle, and `pclk_o` equals the source clock XOR `inv_pclk`.
- R8: If `irq_en` is high, `frame_irq` goes high for exactly one cycle: the first cycle in which both counters are back at 0 after a frame wraps. If `irq_en` was low at that edge, `frame_irq` stays low.
- R9: After a field is reduced so that a counter is at or past its new last value, that counter returns to 0 on its next step instead of running on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pclk_div_m1 | input | 8 | Pixel clock divide ratio minus one |
| hs_wid_m1 | input | 10 | Horizontal sync width minus one |
| hbp_m1 | input | 10 | Horizontal back porch minus one |
| hact_m1 | input | 10 | Active width minus one |
| hfp_m1 | input | 10 | Horizontal front porch minus one |
| vs_wid_m1 | input | 10 | Vertical sync width minus one, in lines |
| vbp_m1 | input | 10 | Vertical back porch minus one |
| vact_m1 | input | 10 | Active height minus one |
| vfp_m1 | input | 10 | Vertical front porch minus one |
| inv_hs | input | 1 | Invert horizontal sync |
| inv_vs | input | 1 | Invert vertical sync |
| inv_de | input | 1 | Invert data-enable |
| inv_pclk | input | 1 | Invert pixel clock |
| irq_en | input | 1 | Enable the frame pulse |
| pclk_o | output | 1 | Pixel clock to the panel |
| pix_ce | output | 1 | Pixel clock enable, one source-clock cycle wide |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data-enable |
| active_o | output | 1 | Inside the active area, before polarity |
| pix_cnt | output | 12 | Position within the line |
| line_cnt | output | 12 | Line within the frame |
| frame_irq | output | 1 | Frame pulse at the start of vertical sync |

## Verification
The bench targets the minus-one encodings at their smallest values: a one-pixel front porch and a one-line vertical sync. A design that dropped the +1 would make these segments vanish or shift the active window by one. It also runs divide ratios of 1, 3 and 4. An off-by-one in the divider would stretch the line, and a missing bypass would stall the counters when the ratio is 1.

The active width is reduced while `pix_cnt` already lies beyond the new end. An equality-based wrap would then run on through the whole counter range. The frame pulse is checked with the enable both on and off. A pulse that came from a level rather than an edge would stay high for a whole divided pixel period.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // span of one segment from its minus-one encoding
  function automatic int unsigned seg_len(input int unsigned m1);
    return m1 + 1;
  endfunction

  // full axis period from the four minus-one fields
  function automatic int unsigned axis_period(input int unsigned s_m1, input int unsigned b_m1,
                                              input int unsigned a_m1, input int unsigned f_m1);
    return seg_len(s_m1) + seg_len(b_m1) + seg_len(a_m1) + seg_len(f_m1);
  endfunction

  // first count of the active segment
  function automatic int unsigned act_first(input int unsigned s_m1, input int unsigned b_m1);
    return seg_len(s_m1) + seg_len(b_m1);
  endfunction

  // number of source cycles the pixel clock spends high
  function automatic int unsigned clk_high_len(input int unsigned div_m1);
    return (div_m1 + 1) / 2;
  endfunction

  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
    logic pclk;
  } pol_t;

endpackage

// File: rtl/pix_tick_gen.sv
module pix_tick_gen #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] div_m1,
  output logic          ce,
  output logic          phase_hi,
  output logic          bypass
);
  import scan_pkg::*;

  logic [DW-1:0] phase;
  logic [DW:0]   high_len;
  logic          last_phase;

  assign bypass     = (div_m1 == '0);
  assign last_phase = (phase >= div_m1);
  assign ce         = bypass | last_phase;
  assign high_len   = (DW+1)'(clk_high_len(32'(div_m1)));
  assign phase_hi   = ({1'b0, phase} < high_len);

  always_ff @(posedge clk) begin
    if (!rst_n)          phase <= '0;
    else if (bypass)     phase <= '0;
    else if (last_phase) phase <= '0;
    else                 phase <= phase + 1'b1;
  end
endmodule

// File: rtl/scan_axis_ctr.sv
module scan_axis_ctr #(
  parameter int HW = 10,
  parameter int CW = HW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [HW-1:0] sync_m1,
  input  logic [HW-1:0] back_m1,
  input  logic [HW-1:0] act_m1,
  input  logic [HW-1:0] front_m1,
  output logic [CW-1:0] cnt,
  output logic          at_end,
  output logic          in_sync,
  output logic          in_act
);
  import scan_pkg::*;

  logic [CW-1:0] sync_stop;
  logic [CW-1:0] act_beg;
  logic [CW-1:0] act_stop;
  logic [CW-1:0] last_cnt;

  assign sync_stop = CW'(seg_len(32'(sync_m1)));
  assign act_beg   = CW'(act_first(32'(sync_m1), 32'(back_m1)));
  assign act_stop  = CW'(act_first(32'(sync_m1), 32'(back_m1)) + seg_len(32'(act_m1)));
  assign last_cnt  = CW'(axis_period(32'(sync_m1), 32'(back_m1), 32'(act_m1), 32'(front_m1)) - 1);

  // at or beyond the end: wrap even after the fields shrink
  assign at_end  = (cnt >= last_cnt);
  assign in_sync = (cnt < sync_stop);
  assign in_act  = (cnt >= act_beg) && (cnt < act_stop);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (step)   cnt <= at_end ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/sync_pol_stage.sv
module sync_pol_stage (
  input  logic            src_clk,
  input  logic            bypass,
  input  logic            phase_hi,
  input  logic            hs_raw,
  input  logic            vs_raw,
  input  logic            de_raw,
  input  scan_pkg::pol_t  inv,
  output logic            pclk_o,
  output logic            hsync_o,
  output logic            vsync_o,
  output logic            de_o
);
  logic clk_raw;

  assign clk_raw = bypass ? src_clk : phase_hi;
  assign pclk_o  = clk_raw ^ inv.pclk;
  assign hsync_o = hs_raw  ^ inv.hs;
  assign vsync_o = vs_raw  ^ inv.vs;
  assign de_o    = de_raw  ^ inv.de;
endmodule

// File: rtl/rgb_scan_timer.sv
module rgb_scan_timer #(
  parameter int HW = 10,
  parameter int DW = 8,
  localparam int CW = HW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] pclk_div_m1,
  input  logic [HW-1:0] hs_wid_m1,
  input  logic [HW-1:0] hbp_m1,
  input  logic [HW-1:0] hact_m1,
  input  logic [HW-1:0] hfp_m1,
  input  logic [HW-1:0] vs_wid_m1,
  input  logic [HW-1:0] vbp_m1,
  input  logic [HW-1:0] vact_m1,
  input  logic [HW-1:0] vfp_m1,
  input  logic          inv_hs,
  input  logic          inv_vs,
  input  logic          inv_de,
  input  logic          inv_pclk,
  input  logic          irq_en,
  output logic          pclk_o,
  output logic          pix_ce,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          active_o,
  output logic [CW-1:0] pix_cnt,
  output logic [CW-1:0] line_cnt,
  output logic          frame_irq
);
  import scan_pkg::*;

  // named internal events, also used by the bound checker
  logic h_end, v_end, h_in_sync, v_in_sync, h_in_act, v_in_act;
  logic v_step, act_raw, div_bypass, div_phase_hi, frame_wrap;
  pol_t inv_sel;

  pix_tick_gen #(.DW(DW)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_m1   (pclk_div_m1),
    .ce       (pix_ce),
    .phase_hi (div_phase_hi),
    .bypass   (div_bypass)
  );

  scan_axis_ctr #(.HW(HW), .CW(CW)) u_hax (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (pix_ce),
    .sync_m1  (hs_wid_m1),
    .back_m1  (hbp_m1),
    .act_m1   (hact_m1),
    .front_m1 (hfp_m1),
    .cnt      (pix_cnt),
    .at_end   (h_end),
    .in_sync  (h_in_sync),
    .in_act   (h_in_act)
  );

  assign v_step = pix_ce & h_end;

  scan_axis_ctr #(.HW(HW), .CW(CW)) u_vax (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (v_step),
    .sync_m1  (vs_wid_m1),
    .back_m1  (vbp_m1),
    .act_m1   (vact_m1),
    .front_m1 (vfp_m1),
    .cnt      (line_cnt),
    .at_end   (v_end),
    .in_sync  (v_in_sync),
    .in_act   (v_in_act)
  );

  assign act_raw    = h_in_act & v_in_act;
  assign active_o   = act_raw;
  assign frame_wrap = v_step & v_end;

  assign inv_sel = '{hs: inv_hs, vs: inv_vs, de: inv_de, pclk: inv_pclk};

  sync_pol_stage u_pol (
    .src_clk  (clk),
    .bypass   (div_bypass),
    .phase_hi (div_phase_hi),
    .hs_raw   (h_in_sync),
    .vs_raw   (v_in_sync),
    .de_raw   (act_raw),
    .inv      (inv_sel),
    .pclk_o   (pclk_o),
    .hsync_o  (hsync_o),
    .vsync_o  (vsync_o),
    .de_o     (de_o)
  );

  // frame pulse: first cycle at the origin after a wrap
  always_ff @(posedge clk) begin
    if (!rst_n) frame_irq <= 1'b0;
    else        frame_irq <= irq_en & frame_wrap;
  end
endmodule

// File: rtl/scan_timer_chk.sv
module scan_timer_chk #(
  parameter int CW = 12,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_en,
  input logic [DW-1:0] div_m1,
  input logic          pix_ce,
  input logic [CW-1:0] pix_cnt,
  input logic [CW-1:0] line_cnt,
  input logic          frame_irq,
  input logic          h_end,
  input logic          h_in_sync,
  input logic          act_raw
);
  assert_ce_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (div_m1 == '0) |-> pix_ce);

  assert_hold_between_ticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_ce |=> ($stable(pix_cnt) && $stable(line_cnt)));

  assert_line_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_ce && h_end) |=> $stable(line_cnt));

  assert_active_outside_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_raw |-> !h_in_sync);

  assert_irq_at_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |-> (pix_cnt == '0 && line_cnt == '0));

  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |=> !frame_irq);

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !frame_irq);
endmodule

bind rgb_scan_timer scan_timer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_en    (irq_en),
  .div_m1    (pclk_div_m1),
  .pix_ce    (pix_ce),
  .pix_cnt   (pix_cnt),
  .line_cnt  (line_cnt),
  .frame_irq (frame_irq),
  .h_end     (h_end),
  .h_in_sync (h_in_sync),
  .act_raw   (act_raw)
);

// File: tb/sim_rgb_scan_timer.sv
module sim_rgb_scan_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] pclk_div_m1 = '0;
  logic [9:0] hs_wid_m1 = 10'd1, hbp_m1 = 10'd1, hact_m1 = 10'd7, hfp_m1 = 10'd0;
  logic [9:0] vs_wid_m1 = 10'd0, vbp_m1 = 10'd1, vact_m1 = 10'd3, vfp_m1 = 10'd0;
  logic inv_hs = 1'b0, inv_vs = 1'b0, inv_de = 1'b0, inv_pclk = 1'b0, irq_en = 1'b1;
  logic pclk_o, pix_ce, hsync_o, vsync_o, de_o, active_o, frame_irq;
  logic [11:0] pix_cnt, line_cnt;

  int vectors = 0, misses = 0, cyc = 0;
  string ph = "R1 reset";

  // behavioural reference state
  int m_div = 0, m_h = 0, m_v = 0;
  bit m_irq = 1'b0;

  always #5 clk = ~clk;

  rgb_scan_timer u0 (
    .clk(clk), .rst_n(rst_n), .pclk_div_m1(pclk_div_m1),
    .hs_wid_m1(hs_wid_m1), .hbp_m1(hbp_m1), .hact_m1(hact_m1), .hfp_m1(hfp_m1),
    .vs_wid_m1(vs_wid_m1), .vbp_m1(vbp_m1), .vact_m1(vact_m1), .vfp_m1(vfp_m1),
    .inv_hs(inv_hs), .inv_vs(inv_vs), .inv_de(inv_de), .inv_pclk(inv_pclk), .irq_en(irq_en),
    .pclk_o(pclk_o), .pix_ce(pix_ce), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .active_o(active_o), .pix_cnt(pix_cnt), .line_cnt(line_cnt), .frame_irq(frame_irq)
  );

  function automatic int line_len();
    return int'(hs_wid_m1) + int'(hbp_m1) + int'(hact_m1) + int'(hfp_m1) + 4;
  endfunction
  function automatic int frame_len();
    return int'(vs_wid_m1) + int'(vbp_m1) + int'(vact_m1) + int'(vfp_m1) + 4;
  endfunction

  always @(posedge clk) begin
    int dv;
    bit tk, hl, vl;
    cyc++;
    if (!rst_n) begin
      m_div = 0; m_h = 0; m_v = 0; m_irq = 1'b0;
    end else begin
      dv = int'(pclk_div_m1);
      tk = (dv == 0) || (m_div >= dv);
      hl = (m_h >= line_len() - 1);
      vl = (m_v >= frame_len() - 1);
      m_irq = irq_en && tk && hl && vl;
      if (dv == 0 || m_div >= dv) m_div = 0; else m_div++;
      if (tk) begin
        if (hl) begin
          m_h = 0;
          m_v = vl ? 0 : m_v + 1;
        end else m_h++;
      end
    end
  end

  task automatic chk(input string req, input string nm, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s [%s] at cycle %0d: got %0d expected %0d", req, nm, ph, cyc, act, exp);
    end
  endtask

  task automatic compare_all();
    int hab, hae, vab, vae, dv;
    bit act, ep;
    hab = int'(hs_wid_m1) + int'(hbp_m1) + 2;
    hae = hab + int'(hact_m1) + 1;
    vab = int'(vs_wid_m1) + int'(vbp_m1) + 2;
    vae = vab + int'(vact_m1) + 1;
    act = (m_h >= hab) && (m_h < hae) && (m_v >= vab) && (m_v < vae);
    dv = int'(pclk_div_m1);
    if (dv == 0) ep = inv_pclk ^ clk;                       // R7 bypass
    else         ep = inv_pclk ^ (m_div < (dv + 1) / 2);    // R6 duty
    chk("R2", "pix_cnt", int'(pix_cnt), m_h);
    chk("R3", "line_cnt", int'(line_cnt), m_v);
    chk("R2,R5", "hsync_o", int'(hsync_o), int'((m_h < int'(hs_wid_m1) + 1) ^ inv_hs));
    chk("R3,R5", "vsync_o", int'(vsync_o), int'((m_v < int'(vs_wid_m1) + 1) ^ inv_vs));
    chk("R4", "active_o", int'(active_o), int'(act));
    chk("R4,R5", "de_o", int'(de_o), int'(act ^ inv_de));
    chk("R6,R7", "pclk_o", int'(pclk_o), int'(ep));
    chk("R6,R7", "pix_ce", int'(pix_ce), int'((dv == 0) || (m_div >= dv)));
    chk("R8", "frame_irq", int'(frame_irq), int'(m_irq));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      compare_all();
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      misses++;
      $display("FAIL watchdog: got %0d cycles expected under 100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    run(3);
    chk("R1", "pix_cnt in reset", int'(pix_cnt), 0);
    chk("R1", "frame_irq in reset", int'(frame_irq), 0);
    rst_n = 1'b1;

    // R2 R3 R4 R7 R8: divide by one, two full frames
    ph = "R7 bypass, irq on";
    run(260);

    // R5 R6: ratio 3 with every polarity inverted
    @(negedge clk);
    pclk_div_m1 = 8'd2;
    inv_hs = 1'b1; inv_vs = 1'b1; inv_de = 1'b1; inv_pclk = 1'b1;
    ph = "R5 inverted, R6 ratio 3";
    run(420);

    // R6: even ratio 4, normal polarity, frame pulse disabled
    inv_hs = 1'b0; inv_vs = 1'b0; inv_de = 1'b0; inv_pclk = 1'b0;
    pclk_div_m1 = 8'd3;
    irq_en = 1'b0;
    ph = "R6 ratio 4, R8 irq off";
    run(520);

    // R9: shrink active width while the pixel counter sits past the new end
    pclk_div_m1 = 8'd0;
    irq_en = 1'b1;
    ph = "R9 shrink";
    run(5);
    while (pix_cnt != 12'd10) run(1);
    hact_m1 = 10'd1;   // new line length 7, last count 6
    run(1);
    chk("R9", "pix_cnt wraps after shrink", int'(pix_cnt), 0);
    run(300);

    // R1: reset in the middle of a frame
    rst_n = 1'b0;
    ph = "R1 mid-run reset";
    run(2);
    chk("R1", "line_cnt after reset", int'(line_cnt), 0);
    rst_n = 1'b1;
    ph = "R2 after reset";
    run(120);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule